// File: doc/BRIEF.md
# Reload-and-match toggle PWM timer

This block makes a pulse-width-modulated waveform from a free-running up-counter. The counter climbs to all-ones and then reloads a programmed start value. The distance from that start value up to all-ones sets the period. Every time the counter wraps, the output line toggles. Every time the counter steps off a programmed match value, the output line toggles again. The high phase therefore lasts from the reload up to and including the match value, and the low phase covers the rest of the period. An optional power-of-two prescaler slows the count rate.

A small two-state controller gates the timer. The states are STOPPED and RUNNING. The GO transition (STOPPED to RUNNING) is taken at the first clock edge that sees `run` high. The HALT transition (RUNNING to STOPPED) is taken at the first clock edge that sees `run` low. In STOPPED, the controller copies the reload value, match value, trigger mode, polarity and prescaler settings into internal configuration registers on every clock. In RUNNING, that copy is frozen.

To begin a run, software stops the timer, presents a new configuration, writes 0xFFFF_FFFE into the counter and raises `run`. With that preload, the first wrap comes two counting ticks after the start, and it drives the line to its active level.

Top module: `toggle_pwm_timer`

## Requirements
- R1: With reload value `L`, overflow strobes are (2^CNT_W - L) counting ticks apart. A counting tick occurs when the counter is at all-ones, and on it the counter takes `L`.
- R2: With trigger mode 2'b10, the line toggles on each overflow and again on the tick that advances the counter past the match value `M`. The level that follows an overflow therefore lasts (M - L + 1) ticks.
- R3: The trigger mode encodings are as follows. 2'b00 never toggles the line. 2'b01 toggles on overflow only. 2'b10 and 2'b11 toggle on both overflow and compare. The strobes fire in every mode.
- R4: After the counter is preloaded with 0xFFFF_FFFE and `run` rises, the first overflow strobe is visible 2*D+1 clock cycles after the GO edge, where D is the prescale factor.
- R5: `pwm_out` equals the internal toggle level XOR the polarity bit. While STOPPED the polarity input takes effect immediately. While RUNNING the captured polarity is used.
- R6: With `pre_en` low, every RUNNING clock is a counting tick. With `pre_en` high, one tick occurs every 2^(pre_val+1) clocks. The prescaler clears whenever the timer is STOPPED.
- R7: In STOPPED, the counter and the toggle level hold their values and no strobe fires. The GO and HALT transitions follow `run` with one clock of latency.
- R8: The reload value, match value, mode, polarity and prescaler settings are captured only in STOPPED. Changing them while RUNNING has no effect until the next GO.
- R9: A counter write (`cnt_wr`) takes priority over counting. It suppresses the overflow and compare events of that clock.
- R10: After reset, the counter, reload value and match value are zero, the state is STOPPED, both strobes are low, and `pwm_out` equals `invert`.
- R11: Each strobe is one clock wide whenever the reload value is not all-ones. Exactly one compare strobe occurs per period.
- R12: When the reload value equals the match value, the overflow and the following compare still produce two separate toggles, giving a one-tick active phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Start (1) / stop (0) control |
| load_val | input | CNT_W | Reload value taken after overflow |
| match_val | input | CNT_W | Compare value |
| cnt_wr | input | 1 | Direct counter write strobe |
| cnt_wdata | input | CNT_W | Data for a direct counter write |
| invert | input | 1 | Output polarity select |
| trig_mode | input | 2 | Toggle trigger mode (see R3) |
| pre_en | input | 1 | Prescaler enable |
| pre_val | input | PTV_W | Prescaler exponent; divides by 2^(pre_val+1) |
| pwm_out | output | 1 | PWM output line |
| ovf_pulse | output | 1 | One-clock overflow event strobe |
| cmp_pulse | output | 1 | One-clock compare event strobe |

## Verification
Some behaviours are checked on every cycle. Each overflow strobe must coincide with the counter holding the captured reload value, and each compare strobe with the counter one step past the match value. The counter must stay frozen in STOPPED unless written. The line may change while RUNNING only alongside a strobe, and may not change at all while STOPPED with a steady polarity. Strobes must stay one clock wide.

Other behaviours depend on real configurations and only the bench scenarios show them. These are:
- the period and active-phase lengths for each trigger mode and prescale factor;
- the start-up latency from the preload;
- counter resumption after a pause;
- configuration freezing while running;
- counter-write priority.

// File: rtl/tpt_pkg.sv
`timescale 1ns/1ps
package tpt_pkg;

    typedef enum logic {
        ST_STOPPED = 1'b0,
        ST_RUNNING = 1'b1
    } run_state_e;

    typedef enum logic [1:0] {
        TRIG_NONE     = 2'b00,
        TRIG_OVF      = 2'b01,
        TRIG_BOTH     = 2'b10,
        TRIG_BOTH_ALT = 2'b11
    } trig_mode_e;

    function automatic logic trig_on_ovf(trig_mode_e m);
        return m != TRIG_NONE;
    endfunction

    function automatic logic trig_on_cmp(trig_mode_e m);
        return (m == TRIG_BOTH) || (m == TRIG_BOTH_ALT);
    endfunction

endpackage

// File: rtl/tpt_ctrl.sv
`timescale 1ns/1ps
// Start/stop state machine plus configuration capture (frozen while running).
module tpt_ctrl
    import tpt_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PTV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] load_in,
    input  logic [CNT_W-1:0] match_in,
    input  logic [1:0]       mode_in,
    input  logic             inv_in,
    input  logic             pre_en_in,
    input  logic [PTV_W-1:0] pre_val_in,
    output logic             running,
    output logic [CNT_W-1:0] load_cfg,
    output logic [CNT_W-1:0] match_cfg,
    output trig_mode_e       mode_cfg,
    output logic             inv_cfg,
    output logic             pre_en_cfg,
    output logic [PTV_W-1:0] pre_val_cfg
);

    run_state_e state_q, state_d;

    // next-state: GO and HALT transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOPPED: if (run)  state_d = ST_RUNNING;
            ST_RUNNING: if (!run) state_d = ST_STOPPED;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOPPED;
        else        state_q <= state_d;
    end

    // outputs: configuration follows the inputs only while stopped
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_cfg    <= '0;
            match_cfg   <= '0;
            mode_cfg    <= TRIG_NONE;
            inv_cfg     <= 1'b0;
            pre_en_cfg  <= 1'b0;
            pre_val_cfg <= '0;
        end else begin
            unique case (state_q)
                ST_STOPPED: begin
                    load_cfg    <= load_in;
                    match_cfg   <= match_in;
                    mode_cfg    <= trig_mode_e'(mode_in);
                    inv_cfg     <= inv_in;
                    pre_en_cfg  <= pre_en_in;
                    pre_val_cfg <= pre_val_in;
                end
                ST_RUNNING: ;
            endcase
        end
    end

    assign running = (state_q == ST_RUNNING);

endmodule

// File: rtl/tpt_prescaler.sv
`timescale 1ns/1ps
// Power-of-two tick divider; cleared while the timer is stopped.
module tpt_prescaler #(
    parameter int PTV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic             pre_en,
    input  logic [PTV_W-1:0] pre_val,
    output logic             tick
);

    localparam int DIV_W = (1 << PTV_W) + 1;

    logic [DIV_W-1:0] pcnt_q;
    logic [DIV_W-1:0] shamt;
    logic [DIV_W-1:0] term;
    logic             at_term;

    always_comb begin
        shamt   = DIV_W'(pre_val) + DIV_W'(1);
        term    = (DIV_W'(1) << shamt) - DIV_W'(1);
        at_term = (pcnt_q == term);
        tick    = running && (!pre_en || at_term);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  pcnt_q <= '0;
        else if (!running || !pre_en) pcnt_q <= '0;
        else if (at_term)             pcnt_q <= '0;
        else                          pcnt_q <= pcnt_q + DIV_W'(1);
    end

endmodule

// File: rtl/tpt_counter.sv
`timescale 1ns/1ps
// Up-counter with reload on wrap, compare detect and event strobes.
module tpt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic [CNT_W-1:0] load,
    input  logic [CNT_W-1:0] match,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf_ev,
    output logic             cmp_ev,
    output logic             ovf_pulse,
    output logic             cmp_pulse
);

    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        ovf_ev = tick && !wr && (cnt_q == ALL_ONES);
        cmp_ev = tick && !wr && (cnt_q == match);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            ovf_pulse <= 1'b0;
            cmp_pulse <= 1'b0;
        end else begin
            if (wr)
                cnt_q <= wdata;
            else if (tick)
                cnt_q <= (cnt_q == ALL_ONES) ? load : cnt_q + CNT_W'(1);
            ovf_pulse <= ovf_ev;
            cmp_pulse <= cmp_ev;
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/tpt_pinout.sv
`timescale 1ns/1ps
// Toggle level register and polarity stage for the output pin.
module tpt_pinout
    import tpt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ovf_ev,
    input  logic       cmp_ev,
    input  trig_mode_e mode,
    input  logic       running,
    input  logic       inv_cfg,
    input  logic       inv_in,
    output logic       pin
);

    logic tog_q;
    logic flip_ovf;
    logic flip_cmp;

    always_comb begin
        flip_ovf = ovf_ev && trig_on_ovf(mode);
        flip_cmp = cmp_ev && trig_on_cmp(mode);
        pin      = tog_q ^ (running ? inv_cfg : inv_in);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tog_q <= 1'b0;
        else        tog_q <= tog_q ^ flip_ovf ^ flip_cmp;
    end

endmodule

// File: rtl/toggle_pwm_timer.sv
`timescale 1ns/1ps
module toggle_pwm_timer
    import tpt_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PTV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] match_val,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             invert,
    input  logic [1:0]       trig_mode,
    input  logic             pre_en,
    input  logic [PTV_W-1:0] pre_val,
    output logic             pwm_out,
    output logic             ovf_pulse,
    output logic             cmp_pulse
);

    logic             running;
    logic [CNT_W-1:0] load_cfg;
    logic [CNT_W-1:0] match_cfg;
    trig_mode_e       mode_cfg;
    logic             inv_cfg;
    logic             pre_en_cfg;
    logic [PTV_W-1:0] pre_val_cfg;
    logic             tick;
    logic [CNT_W-1:0] cnt_q;
    logic             ovf_ev;
    logic             cmp_ev;

    tpt_ctrl #(.CNT_W(CNT_W), .PTV_W(PTV_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .load_in    (load_val),
        .match_in   (match_val),
        .mode_in    (trig_mode),
        .inv_in     (invert),
        .pre_en_in  (pre_en),
        .pre_val_in (pre_val),
        .running    (running),
        .load_cfg   (load_cfg),
        .match_cfg  (match_cfg),
        .mode_cfg   (mode_cfg),
        .inv_cfg    (inv_cfg),
        .pre_en_cfg (pre_en_cfg),
        .pre_val_cfg(pre_val_cfg)
    );

    tpt_prescaler #(.PTV_W(PTV_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .running(running),
        .pre_en (pre_en_cfg),
        .pre_val(pre_val_cfg),
        .tick   (tick)
    );

    tpt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .wr       (cnt_wr),
        .wdata    (cnt_wdata),
        .load     (load_cfg),
        .match    (match_cfg),
        .cnt      (cnt_q),
        .ovf_ev   (ovf_ev),
        .cmp_ev   (cmp_ev),
        .ovf_pulse(ovf_pulse),
        .cmp_pulse(cmp_pulse)
    );

    tpt_pinout u_pin (
        .clk    (clk),
        .rst_n  (rst_n),
        .ovf_ev (ovf_ev),
        .cmp_ev (cmp_ev),
        .mode   (mode_cfg),
        .running(running),
        .inv_cfg(inv_cfg),
        .inv_in (invert),
        .pin    (pwm_out)
    );

endmodule

// File: rtl/tpt_checker.sv
`timescale 1ns/1ps
module tpt_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             running,
    input logic [CNT_W-1:0] cnt,
    input logic             cnt_wr,
    input logic [CNT_W-1:0] load_cfg,
    input logic [CNT_W-1:0] match_cfg,
    input logic             invert,
    input logic             pwm_out,
    input logic             ovf_pulse,
    input logic             cmp_pulse
);

    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    assert_ovf_reload_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> (cnt == load_cfg));

    assert_cmp_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_pulse && match_cfg != ALL_ONES) |-> (cnt == match_cfg + CNT_W'(1)));

    assert_toggle_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running) && pwm_out != $past(pwm_out)) |-> (ovf_pulse || cmp_pulse));

    assert_hold_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(running) && !$past(cnt_wr)) |-> (cnt == $past(cnt)));

    assert_quiet_pin_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !$past(running) && $stable(invert)) |-> $stable(pwm_out));

    assert_ovf_width_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_pulse && load_cfg != ALL_ONES) |=> !ovf_pulse);

    assert_cmp_width_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_pulse && load_cfg != ALL_ONES) |=> !cmp_pulse);

endmodule

bind toggle_pwm_timer tpt_checker #(.CNT_W(CNT_W)) u_tpt_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .running  (running),
    .cnt      (cnt_q),
    .cnt_wr   (cnt_wr),
    .load_cfg (load_cfg),
    .match_cfg(match_cfg),
    .invert   (invert),
    .pwm_out  (pwm_out),
    .ovf_pulse(ovf_pulse),
    .cmp_pulse(cmp_pulse)
);

// File: tb/toggle_pwm_timer_test.sv
`timescale 1ns/1ps
module toggle_pwm_timer_test;

    typedef struct packed {
        logic [15:0] per;
        logic [15:0] duty;
        logic        pe;
        logic [2:0]  ptv;
        logic [1:0]  mode;
        logic        inv;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{16'd10, 16'd3, 1'b0, 3'd0, 2'd2, 1'b0},
        '{16'd10, 16'd3, 1'b0, 3'd0, 2'd2, 1'b1},
        '{16'd2,  16'd1, 1'b0, 3'd0, 2'd2, 1'b0},
        '{16'd8,  16'd7, 1'b0, 3'd0, 2'd3, 1'b0},
        '{16'd6,  16'd2, 1'b1, 3'd0, 2'd2, 1'b0},
        '{16'd5,  16'd2, 1'b1, 3'd2, 2'd2, 1'b1},
        '{16'd7,  16'd3, 1'b0, 3'd0, 2'd1, 1'b0},
        '{16'd4,  16'd2, 1'b0, 3'd0, 2'd0, 1'b0},
        '{16'd3,  16'd1, 1'b1, 3'd7, 2'd2, 1'b0},
        '{16'd5,  16'd1, 1'b0, 3'd0, 2'd2, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        run;
    logic [31:0] load_val;
    logic [31:0] match_val;
    logic        cnt_wr;
    logic [31:0] cnt_wdata;
    logic        invert;
    logic [1:0]  trig_mode;
    logic        pre_en;
    logic [2:0]  pre_val;
    logic        pwm_out;
    logic        ovf_pulse;
    logic        cmp_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    toggle_pwm_timer uut (
        .clk(clk), .rst_n(rst_n), .run(run), .load_val(load_val),
        .match_val(match_val), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .invert(invert), .trig_mode(trig_mode), .pre_en(pre_en),
        .pre_val(pre_val), .pwm_out(pwm_out), .ovf_pulse(ovf_pulse),
        .cmp_pulse(cmp_pulse)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic configure(input int per, input int duty, input bit pe,
                             input int ptv, input int mode, input bit inv);
        @(negedge clk);
        run = 1'b0;
        repeat (3) @(negedge clk);
        load_val  = 32'hFFFF_FFFF - 32'(per) + 32'd1;
        match_val = 32'hFFFF_FFFF - 32'(per) + 32'(duty);
        pre_en    = pe;
        pre_val   = 3'(ptv);
        trig_mode = 2'(mode);
        invert    = inv;
        cnt_wr    = 1'b1;
        cnt_wdata = 32'hFFFF_FFFE;
        @(negedge clk);
        cnt_wr    = 1'b0;
        @(negedge clk);
    endtask

    task automatic start_wait_ovf(output int n);
        run = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!ovf_pulse && n < 100000);
    endtask

    task automatic measure(output int per, output int hi, output int ncmp);
        logic ref_lvl;
        ref_lvl = pwm_out;
        per = 0; hi = 0; ncmp = 0;
        do begin
            if (pwm_out == ref_lvl) hi++;
            @(negedge clk);
            per++;
            if (cmp_pulse) ncmp++;
        end while (!ovf_pulse && per < 100000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R7 watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n, per, hi, ncmp, div;
        logic lvl;
        rst_n = 1'b0; run = 1'b0; load_val = '0; match_val = '0;
        cnt_wr = 1'b0; cnt_wdata = '0; invert = 1'b0; trig_mode = 2'd2;
        pre_en = 1'b0; pre_val = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R10 reset state
        check(pwm_out == 1'b0, "R10", "reset pin", pwm_out, 0);
        check(ovf_pulse == 1'b0, "R10", "reset ovf strobe", ovf_pulse, 0);
        check(cmp_pulse == 1'b0, "R10", "reset cmp strobe", cmp_pulse, 0);
        invert = 1'b1;
        @(negedge clk);
        check(pwm_out == 1'b1, "R5", "stopped polarity", pwm_out, 1);

        // table-driven periods
        for (int i = 0; i < NV; i++) begin
            configure(int'(VECS[i].per), int'(VECS[i].duty), VECS[i].pe,
                      int'(VECS[i].ptv), int'(VECS[i].mode), VECS[i].inv);
            div = VECS[i].pe ? (1 << (int'(VECS[i].ptv) + 1)) : 1;
            lvl = pwm_out;
            start_wait_ovf(n);
            check(n == 2*div + 1, "R4 R6", "first overflow latency", n, 2*div + 1);
            measure(per, hi, ncmp);
            check(per == int'(VECS[i].per) * div, "R1 R6", "period", per, int'(VECS[i].per) * div);
            if (VECS[i].mode[1])
                check(hi == int'(VECS[i].duty) * div, "R2 R12", "active phase", hi, int'(VECS[i].duty) * div);
            else
                check(hi == per, "R3", "no compare toggle", hi, per);
            check(ncmp == 1, "R11", "compare strobes per period", ncmp, 1);
            if (VECS[i].mode == 2'd0)
                check(pwm_out == lvl, "R3", "mode none pin steady", pwm_out, lvl);
        end

        // R7 stop holds counter and pin, resume continues
        configure(10, 3, 1'b0, 0, 2, 1'b0);
        start_wait_ovf(n);
        run = 1'b0;
        @(negedge clk);
        lvl = pwm_out;
        n = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (ovf_pulse || cmp_pulse || pwm_out != lvl) n++;
        end
        check(n == 0, "R7", "activity while stopped", n, 0);
        start_wait_ovf(n);
        check(n == 10, "R7", "resume latency", n, 10);

        // R8 configuration frozen while running
        load_val  = 32'hFFFF_FFFC;
        match_val = 32'hFFFF_FFFC;
        trig_mode = 2'd0;
        pre_en    = 1'b1;
        invert    = 1'b1;
        measure(per, hi, ncmp);
        check(per == 10, "R8", "frozen period", per, 10);
        check(hi == 3, "R8", "frozen active phase", hi, 3);

        // R9 counter write priority and event suppression
        cnt_wr = 1'b1; cnt_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        cnt_wr = 1'b0;
        @(negedge clk);
        check(ovf_pulse == 1'b1, "R9", "overflow after write", ovf_pulse, 1);
        cnt_wr = 1'b1; cnt_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        cnt_wdata = 32'hFFFF_FFF0;
        @(negedge clk);
        cnt_wr = 1'b0;
        check(ovf_pulse == 1'b0, "R9", "overflow suppressed by write", ovf_pulse, 0);
        run = 1'b0;
        repeat (3) @(negedge clk);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule